// File: doc/BRIEF.md
# Banked Dual-File Register File

This block holds two register files of equal size, one for integer (general-purpose) values and one for floating-point values. Both are addressed with the same register numbers, and a file-select bit on each access picks which file is meant. Each file is split into two physical banks by the lowest address bit: even-numbered registers in one bank and odd-numbered registers in the other. Each bank has a single read port.

A read request names two source registers. If the two sources sit in different banks, both are returned together one cycle later. If they sit in the same bank, the block raises a conflict flag for one cycle and serialises the two reads. The first source is read in the request cycle and the second in the next cycle. Both values are then presented together with the valid flag.

The single write port can store one register, or it can store a double-width result into an aligned even/odd pair. In the integer file, register zero is hard-wired to read as zero.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register of both files reads as zero, and `rd_valid`, `conflict` and `wr_err` are low.
- R2: Bit 0 of a register number selects its bank (0 = even bank, 1 = odd bank). A request whose two sources differ in bit 0 returns both values with `rd_valid` high and `conflict` low in the cycle after the request.
- R3: A request whose two sources share bit 0 gives `conflict` high and `rd_valid` low in the cycle after the request. In the following cycle, `conflict` is low and `rd_valid` is high, with both values present.
- R4: A read request presented while `conflict` is high is dropped. It produces no later `rd_valid`, and it does not alter the pending result.
- R5: File select is 0 for the integer file and 1 for the floating-point file, on both reads and writes. The same register number in the two files refers to independent storage.
- R6: Integer register 0 always reads as zero, and writes to it are discarded. Floating-point register 0 is an ordinary register.
- R7: A double-width write to an even number n stores `wr_data_lo` in register n and `wr_data_hi` in register n+1 of the selected file, in one cycle.
- R8: A double-width write to an odd number writes nothing and sets `wr_err` high for the single cycle after the write.
- R9: A read of a register written in the same cycle returns the value held before that write. The new value is visible to reads in later cycles.
- R10: A single-width write stores `wr_data_lo` in one register and leaves its neighbour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request for the two sources |
| rd_fp | input | 1 | File select for the read (1 = floating point) |
| rd_addr_a | input | 5 | First source register number |
| rd_addr_b | input | 5 | Second source register number |
| wr_en | input | 1 | Write enable |
| wr_fp | input | 1 | File select for the write |
| wr_dbl | input | 1 | Double-width pair write |
| wr_addr | input | 5 | Destination register number |
| wr_data_lo | input | 32 | Single value, or low half of a pair |
| wr_data_hi | input | 32 | High half of a pair |
| rd_data_a | output | 32 | Value of the first source |
| rd_data_b | output | 32 | Value of the second source |
| rd_valid | output | 1 | Both source values are present |
| conflict | output | 1 | Same-bank request is being serialised |
| wr_err | output | 1 | Previous pair write had an odd address |

## Verification
The bench targets the same-bank case with sources such as 3 and 31. A design that fetched both sources from one port would either present valid a cycle early or return the first value twice. It also holds a second request during the stall cycle; a design that did not drop that request would produce a stray valid cycle afterwards.

Pair writes are checked in three cases: an even destination, an odd destination, and integer register 0. These expose a swapped high/low half, a write that escapes the odd-address suppression, and a register zero that becomes writable. A read of the register being written in the same cycle shows whether the design forwards the new value when it must return the old one.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_req,
  input  logic                     rd_fp,
  input  logic [$clog2(NREGS)-1:0] rd_addr_a,
  input  logic [$clog2(NREGS)-1:0] rd_addr_b,
  input  logic                     wr_en,
  input  logic                     wr_fp,
  input  logic                     wr_dbl,
  input  logic [$clog2(NREGS)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data_lo,
  input  logic [WIDTH-1:0]         wr_data_hi,
  output logic [WIDTH-1:0]         rd_data_a,
  output logic [WIDTH-1:0]         rd_data_b,
  output logic                     rd_valid,
  output logic                     conflict,
  output logic                     wr_err
);
  localparam int AW    = $clog2(NREGS);
  localparam int DEPTH = NREGS / 2;
  localparam int IW    = AW - 1;

  logic [WIDTH-1:0] mem [2][2][DEPTH];

  logic          pend;
  logic [AW-1:0] pend_addr;
  logic          pend_fp;

  logic [IW-1:0]    bank_idx [2];
  logic             bank_fp  [2];
  logic [WIDTH-1:0] bank_q   [2];

  wire same_bank = rd_addr_a[0] == rd_addr_b[0];
  wire accept    = rd_req && !pend;

  assign conflict = pend;

  // one read port per bank; during a stall only the pending operand's bank is used
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      if (pend)
        bank_idx[b] = pend_addr[AW-1:1];
      else if (rd_addr_a[0] == 1'(b))
        bank_idx[b] = rd_addr_a[AW-1:1];
      else
        bank_idx[b] = rd_addr_b[AW-1:1];
      bank_fp[b] = pend ? pend_fp : rd_fp;
      if (b == 0 && !bank_fp[b] && bank_idx[b] == '0)
        bank_q[b] = '0;
      else
        bank_q[b] = mem[bank_fp[b]][b][bank_idx[b]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_fp   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else if (pend) begin
      rd_data_b <= bank_q[pend_addr[0]];
      rd_valid  <= 1'b1;
      pend      <= 1'b0;
    end else if (accept) begin
      rd_data_a <= bank_q[rd_addr_a[0]];
      if (same_bank) begin
        pend      <= 1'b1;
        pend_addr <= rd_addr_b;
        pend_fp   <= rd_fp;
        rd_valid  <= 1'b0;
      end else begin
        rd_data_b <= bank_q[rd_addr_b[0]];
        rd_valid  <= 1'b1;
      end
    end else begin
      rd_valid <= 1'b0;
    end
  end

  wire [IW-1:0] w_idx    = wr_addr[AW-1:1];
  wire          w_gp0    = !wr_fp && w_idx == '0;
  wire          dbl_bad  = wr_en && wr_dbl && wr_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 2; b++)
          for (int i = 0; i < DEPTH; i++)
            mem[f][b][i] <= '0;
    end else begin
      wr_err <= dbl_bad;
      if (wr_en) begin
        if (wr_dbl) begin
          if (!wr_addr[0]) begin
            if (!w_gp0) mem[wr_fp][0][w_idx] <= wr_data_lo;
            mem[wr_fp][1][w_idx] <= wr_data_hi;
          end
        end else if (!(w_gp0 && !wr_addr[0])) begin
          mem[wr_fp][wr_addr[0]][w_idx] <= wr_data_lo;
        end
      end
    end
  end

  p_conflict_then_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> (rd_valid && !conflict));

  p_no_valid_during_conflict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(conflict && rd_valid));

  p_split_banks_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !conflict && rd_addr_a[0] != rd_addr_b[0]) |=> (rd_valid && !conflict));

  p_same_bank_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !conflict && rd_addr_a[0] == rd_addr_b[0]) |=> (conflict && !rd_valid));

  p_dropped_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && rd_req) |=> ##1 !rd_valid);

  p_gp_zero_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !conflict && !rd_fp && rd_addr_a == '0) |=> rd_data_a == '0);

  p_odd_pair_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dbl && wr_addr[0]) |=> wr_err);

  p_no_spurious_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_dbl && wr_addr[0]) |=> !wr_err);
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, rd_fp, wr_en, wr_fp, wr_dbl;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] wr_data_lo, wr_data_hi;
  logic [31:0] rd_data_a, rd_data_b;
  logic        rd_valid, conflict, wr_err;

  int tests = 0;
  int fails = 0;
  logic [31:0] model [2][32];

  always #10 clk = ~clk;

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_fp(rd_fp),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_en(wr_en), .wr_fp(wr_fp),
    .wr_dbl(wr_dbl), .wr_addr(wr_addr), .wr_data_lo(wr_data_lo), .wr_data_hi(wr_data_hi),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_valid(rd_valid),
    .conflict(conflict), .wr_err(wr_err)
  );

  // {file, register, value}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 5'd3,  32'h1111_0003},
    {1'b1, 5'd3,  32'hF000_0003},
    {1'b0, 5'd4,  32'h2222_0004},
    {1'b1, 5'd10, 32'hF000_000A},
    {1'b0, 5'd31, 32'h3333_001F},
    {1'b1, 5'd0,  32'hF0F0_0000},
    {1'b0, 5'd0,  32'hDEAD_BEEF},
    {1'b0, 5'd16, 32'h4444_0010}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 32; i++)
        model[f][i] = '0;
  endtask

  task automatic do_write(input logic fp, input logic dbl, input logic [4:0] a,
                          input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    wr_en = 1; wr_fp = fp; wr_dbl = dbl; wr_addr = a; wr_data_lo = lo; wr_data_hi = hi;
    @(posedge clk);
    if (dbl) begin
      if (!a[0]) begin
        if (fp || a != 0) model[fp][a] = lo;
        model[fp][a+1] = hi;
      end
    end else if (fp || a != 0) begin
      model[fp][a] = lo;
    end
    @(negedge clk);
    wr_en = 0;
    chk(wr_err == (dbl && a[0]), "R8 wr_err after write", 32'(wr_err), 32'(dbl && a[0]));
  endtask

  task automatic do_read(input logic fp, input logic [4:0] a, input logic [4:0] b, input string tag);
    bit same = (a[0] == b[0]);
    @(negedge clk);
    rd_req = 1; rd_fp = fp; rd_addr_a = a; rd_addr_b = b;
    @(posedge clk);
    @(negedge clk);
    rd_req = 0;
    if (same) begin
      chk(conflict && !rd_valid, {tag, " R3 stall cycle"}, {30'd0, conflict, rd_valid}, 32'h2);
      @(posedge clk);
      @(negedge clk);
    end else begin
      chk(!conflict, {tag, " R2 no conflict"}, 32'(conflict), 32'h0);
    end
    chk(rd_valid, {tag, " valid"}, 32'(rd_valid), 32'h1);
    chk(rd_data_a == model[fp][a], {tag, " operand A"}, rd_data_a, model[fp][a]);
    chk(rd_data_b == model[fp][b], {tag, " operand B"}, rd_data_b, model[fp][b]);
  endtask

  initial begin
    #(20 * 100000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rd_req = 0; rd_fp = 0; rd_addr_a = 0; rd_addr_b = 0;
    wr_en = 0; wr_fp = 0; wr_dbl = 0; wr_addr = 0; wr_data_lo = 0; wr_data_hi = 0;
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!rd_valid && !conflict && !wr_err, "R1 outputs after reset",
        {29'd0, rd_valid, conflict, wr_err}, 32'h0);
    do_read(0, 3, 2, "R1 gp reset");
    do_read(1, 7, 6, "R1 fp reset");

    // R5 R6 R10: table of single writes, then read each back beside its neighbour
    foreach (VEC[i]) do_write(VEC[i][37], 1'b0, VEC[i][36:32], VEC[i][31:0], 32'h0);
    foreach (VEC[i]) do_read(VEC[i][37], VEC[i][36:32], VEC[i][36:32] ^ 5'd1, "R5 R10 table");
    do_read(0, 0, 1, "R6 gp zero");

    do_read(0, 3, 31, "R3 same odd bank");
    do_read(1, 10, 0, "R3 same even bank fp");

    // R4: hold a different request through the stall cycle
    @(negedge clk);
    rd_req = 1; rd_fp = 0; rd_addr_a = 4; rd_addr_b = 16;
    @(posedge clk);
    @(negedge clk);
    rd_addr_a = 3; rd_addr_b = 5;
    @(posedge clk);
    @(negedge clk);
    rd_req = 0;
    chk(rd_valid && rd_data_a == model[0][4], "R4 pending A kept", rd_data_a, model[0][4]);
    chk(rd_data_b == model[0][16], "R4 pending B kept", rd_data_b, model[0][16]);
    @(posedge clk);
    @(negedge clk);
    chk(!rd_valid, "R4 dropped request gives no valid", 32'(rd_valid), 32'h0);

    // R7 R8: pair writes
    do_write(0, 1, 6, 32'hAAAA_0006, 32'hBBBB_0007);
    do_read(0, 6, 7, "R7 even pair");
    do_write(1, 1, 9, 32'hCCCC_0009, 32'hDDDD_000A);
    do_read(1, 9, 10, "R8 odd pair suppressed");
    do_read(1, 8, 11, "R8 odd pair neighbours");
    do_write(0, 1, 0, 32'h5555_0000, 32'h6666_0001);
    do_read(0, 0, 1, "R6 R7 pair at gp zero");

    // R9: read and write the same register in one cycle
    @(negedge clk);
    rd_req = 1; rd_fp = 0; rd_addr_a = 4; rd_addr_b = 5;
    wr_en = 1; wr_fp = 0; wr_dbl = 0; wr_addr = 4; wr_data_lo = 32'h9999_0004;
    @(posedge clk);
    @(negedge clk);
    rd_req = 0; wr_en = 0;
    chk(rd_data_a == model[0][4], "R9 old value returned", rd_data_a, model[0][4]);
    model[0][4] = 32'h9999_0004;
    do_read(0, 4, 5, "R9 new value later");

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    clear_model();
    do_read(0, 31, 4, "R1 gp after reset");
    do_read(1, 3, 0, "R1 fp after reset");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule